// File: doc/BRIEF.md
# Dual-Clock FIFO with Early Full Flags

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. The producer sees a write request, a data input and a full flag, all timed by the write clock. The consumer sees a read request, the head-of-queue word and an empty flag, all timed by the read clock. The consumer also gets its own full flag, timed by the read clock, so logic on that side can tell when the buffer is close to its limit.

Each side keeps a binary pointer and publishes a Gray-coded copy. The copy passes through a multi-flop synchronizer into the other domain. Because each side only sees a delayed view of the other side's pointer, the full flags assert early. They keep a guard band of unused slots, three by default. This prevents any overrun, at the cost of the deepest slots never being filled. A user who needs N guaranteed entries should set the depth to at least N plus the guard band. The depth must be a power of two greater than two. Elaboration rejects any other value.

The read port works in show-ahead mode: while the buffer is not empty, the read data output already carries the oldest word. A read request then consumes that word.

Top module: `xdom_fifo`

## Requirements
- R1: While the asynchronous active-low reset is low, and directly after it is released, `rdEmpty` is 1 and both `wrFull` and `rdFull` are 0.
- R2: Every accepted word leaves the read side exactly once, in the order it was written, for any ratio of the two clock rates and any pattern of request gaps.
- R3: A write request made while `wrFull` is 1 is dropped. No stored word changes, and the dropped word never appears at the read side.
- R4: A read request made while `rdEmpty` is 1 is ignored. The read pointer does not move, so the next written word is still the next one read.
- R5: With the read side idle, `wrFull` rises at the same write-clock edge that accepts word number DEPTH-GUARD (5 with the defaults). No more words are accepted after that.
- R6: After a read, `wrFull` stays high until the read has crossed the synchronizer. When both clocks share their edges, it falls at the third write-clock edge after the read edge.
- R7: `rdFull` rises in the read domain once the read side's view of occupancy reaches DEPTH-GUARD. It falls at the read edge that takes occupancy below that level.
- R8: `rdEmpty` falls no earlier than the write has crossed the synchronizer. With shared clock edges, it falls at the third read-clock edge after the write edge. It rises at the read edge that takes the last stored word.
- R9: Whenever `rdEmpty` is 0, `rdData` carries the oldest unread word before any read request is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| wrClk | input | 1 | Write-side clock |
| wrReq | input | 1 | Write request, sampled on wrClk |
| wrData | input | DATA_W | Word to store |
| wrFull | output | 1 | Full flag in the write domain, raised with a guard band |
| rdClk | input | 1 | Read-side clock |
| rdReq | input | 1 | Read request, sampled on rdClk |
| rdData | output | DATA_W | Oldest unread word (show-ahead) |
| rdEmpty | output | 1 | Empty flag in the read domain |
| rdFull | output | 1 | Full flag in the read domain |

## Verification
Two events can land on the same instant:
- A push on the write side and a pop on the read side. When the clocks run at equal rates with aligned edges, both happen at the same timestamp while the buffer holds only a few words. The bench provokes this by streaming both sides at once, with gaps and without, and judges it by comparing every popped word against a reference queue.
- A full flag releasing just as a new write request is waiting. The bench provokes this with the fast-writer rows, where the write side sits against `wrFull`. Any early release would show up as a lost or duplicated word in the same queue comparison.

The aligned-clock directed tests also pin the exact edge at which each flag moves after crossing the synchronizer.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

  // Strobe bundle from the control block to the storage block
  typedef struct packed {
    logic wrEn;   // store wrData at wrAddr on this write edge
  } fifo_strb_t;

  // Binary to reflected Gray code, 32-bit container
  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Reflected Gray code back to binary, 32-bit container
  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/xdom_sync.sv
module xdom_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/xdom_fifo_store.sv
module xdom_fifo_store
  import xdom_fifo_pkg::*;
#(
  parameter  int DATA_W = 8,
  parameter  int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  fifo_strb_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.wrEn) mem[wrAddr] <= wrData;
  end

  // Show-ahead read: the head word is visible without a request
  assign rdData = mem[rdAddr];

endmodule

// File: rtl/xdom_fifo_ctrl.sv
module xdom_fifo_ctrl
  import xdom_fifo_pkg::*;
#(
  parameter  int DEPTH       = 8,
  parameter  int GUARD       = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(DEPTH),
  localparam int PTR_W       = ADDR_W + 1
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              wrReq,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdReq,
  output logic              rdEmpty,
  output logic              rdFull,
  output fifo_strb_t        strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);

  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH - GUARD);

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, wrBinNext, wrUsedNext;
  logic [PTR_W-1:0] rdGrayW, rdBinW;
  logic             wrAccept;

  assign wrAccept   = wrReq & ~wrFull;
  assign wrBinNext  = wrBin + PTR_W'(wrAccept);
  assign rdBinW     = PTR_W'(gray2bin(32'(rdGrayW)));
  assign wrUsedNext = wrBinNext - rdBinW;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      wrFull <= 1'b0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= PTR_W'(bin2gray(32'(wrBinNext)));
      wrFull <= (wrUsedNext >= LIMIT);
    end
  end

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rdBin, rdGray, rdBinNext, rdUsedNext;
  logic [PTR_W-1:0] wrGrayR, wrBinR;
  logic             rdAccept;

  assign rdAccept   = rdReq & ~rdEmpty;
  assign rdBinNext  = rdBin + PTR_W'(rdAccept);
  assign wrBinR     = PTR_W'(gray2bin(32'(wrGrayR)));
  assign rdUsedNext = wrBinR - rdBinNext;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin   <= '0;
      rdGray  <= '0;
      rdEmpty <= 1'b1;
      rdFull  <= 1'b0;
    end else begin
      rdBin   <= rdBinNext;
      rdGray  <= PTR_W'(bin2gray(32'(rdBinNext)));
      rdEmpty <= (rdBinNext == wrBinR);
      rdFull  <= (rdUsedNext >= LIMIT);
    end
  end

  // ---------------- pointer crossings ----------------
  xdom_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_rdToWr (
    .clk  (wrClk),
    .rstN (rstN),
    .din  (rdGray),
    .dout (rdGrayW)
  );

  xdom_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_wrToRd (
    .clk  (rdClk),
    .rstN (rstN),
    .din  (wrGray),
    .dout (wrGrayR)
  );

  assign strb.wrEn = wrAccept;
  assign wrAddr    = wrBin[ADDR_W-1:0];
  assign rdAddr    = rdBin[ADDR_W-1:0];

endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo
  import xdom_fifo_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DEPTH       = 8,
  parameter int GUARD       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rstN,
  input  logic              wrClk,
  input  logic              wrReq,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty,
  output logic              rdFull
);

  localparam int ADDR_W = $clog2(DEPTH);

  if (DEPTH <= 2 || (DEPTH & (DEPTH - 1)) != 0 || GUARD >= DEPTH || GUARD < 1
      || SYNC_STAGES < 2) begin : g_badCfg
    $error("xdom_fifo: DEPTH must be a power of two above 2, with 1 <= GUARD < DEPTH and SYNC_STAGES >= 2");
  end

  fifo_strb_t        strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  xdom_fifo_ctrl #(
    .DEPTH       (DEPTH),
    .GUARD       (GUARD),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .rstN    (rstN),
    .wrClk   (wrClk),
    .wrReq   (wrReq),
    .wrFull  (wrFull),
    .rdClk   (rdClk),
    .rdReq   (rdReq),
    .rdEmpty (rdEmpty),
    .rdFull  (rdFull),
    .strb    (strb),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr)
  );

  xdom_fifo_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .wrClk  (wrClk),
    .strb   (strb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );

endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk #(
  parameter  int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input logic              rstN,
  input logic              wrClk,
  input logic              wrReq,
  input logic              wrFull,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              rdClk,
  input logic              rdReq,
  input logic              rdEmpty,
  input logic              rdFull,
  input logic [ADDR_W-1:0] rdAddr
);

  always @(posedge rdClk) begin
    if (!rstN) begin
      AST_RESET_RD_FLAGS: assert (rdEmpty && !rdFull) else $error("read flags wrong in reset"); // R1
    end
  end

  always @(posedge wrClk) begin
    if (!rstN) begin
      AST_RESET_WR_FLAG: assert (!wrFull && !wrEn) else $error("write flag wrong in reset"); // R1
    end
  end

  AST_WRITE_ADVANCES: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrReq && !wrFull) |=> (wrAddr == ADDR_W'($past(wrAddr) + 1'b1)))
    else $error("accepted write did not advance the pointer"); // R2

  AST_FULL_DROPS_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrReq && wrFull) |=> $stable(wrAddr))
    else $error("write pointer moved while full"); // R3

  AST_EMPTY_DROPS_READ: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdReq && rdEmpty) |=> $stable(rdAddr))
    else $error("read pointer moved while empty"); // R4

  AST_FULL_RISES_ON_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(wrFull) |-> $past(wrReq && !wrFull))
    else $error("write full rose without an accepted write"); // R5

  AST_EMPTY_RISES_ON_READ: assert property (@(posedge rdClk) disable iff (!rstN)
    $rose(rdEmpty) |-> $past(rdReq && !rdEmpty))
    else $error("empty rose without an accepted read"); // R8

endmodule

bind xdom_fifo xdom_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .rstN    (rstN),
  .wrClk   (wrClk),
  .wrReq   (wrReq),
  .wrFull  (wrFull),
  .wrEn    (strb.wrEn),
  .wrAddr  (wrAddr),
  .rdClk   (rdClk),
  .rdReq   (rdReq),
  .rdEmpty (rdEmpty),
  .rdFull  (rdFull),
  .rdAddr  (rdAddr)
);

// File: tb/sim_xdom_fifo.sv
`timescale 1ns/1ps
module sim_xdom_fifo;

  localparam int DW    = 8;
  localparam int DEPTH = 8;
  localparam int GUARD = 3;
  localparam int LIMIT = DEPTH - GUARD;

  // Scenario rows: wrHalf, rdHalf, wrSkip, rdSkip, words
  localparam int NROW = 6;
  localparam int VEC [NROW][5] = '{
    '{5,  5, 0, 0, 40},
    '{5, 13, 0, 0, 40},
    '{13, 5, 0, 0, 40},
    '{5,  7, 3, 0, 40},
    '{7,  5, 0, 3, 40},
    '{5, 23, 2, 4, 30}
  };

  logic          rstN = 1'b1;
  logic          wrClk = 1'b0, rdClk = 1'b0;
  logic          wrReq = 1'b0, rdReq = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          wrFull, rdEmpty, rdFull;

  int wrHalf = 5;
  int rdHalf = 5;
  int total = 0;
  int bad = 0;
  logic [DW-1:0] refQ [$];

  always #(wrHalf) wrClk = ~wrClk;
  always #(rdHalf) rdClk = ~rdClk;

  xdom_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .GUARD(GUARD), .SYNC_STAGES(2)) u0 (
    .rstN    (rstN),
    .wrClk   (wrClk),
    .wrReq   (wrReq),
    .wrData  (wrData),
    .wrFull  (wrFull),
    .rdClk   (rdClk),
    .rdReq   (rdReq),
    .rdData  (rdData),
    .rdEmpty (rdEmpty),
    .rdFull  (rdFull)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    #1 rstN = 1'b0;
    #40 rstN = 1'b1;
    #3;
  endtask

  task automatic wrTry(input logic [DW-1:0] v, output bit acc);
    bit seen;
    @(posedge wrClk); #1;
    wrReq = 1'b1; wrData = v; seen = wrFull;
    @(posedge wrClk); #1;
    wrReq = 1'b0;
    acc = !seen;
    if (acc) refQ.push_back(v);
  endtask

  task automatic rdTry(output bit got, output logic [DW-1:0] v);
    bit seen;
    @(posedge rdClk); #1;
    rdReq = 1'b1; seen = rdEmpty; v = rdData;
    @(posedge rdClk); #1;
    rdReq = 1'b0;
    got = !seen;
  endtask

  task automatic popCheck(input logic [DW-1:0] v, input string req);
    logic [DW-1:0] e;
    if (refQ.size() == 0) begin
      check(1'b0, req, int'(v), -1);
    end else begin
      e = refQ.pop_front();
      check(v == e, req, int'(v), int'(e));
    end
  endtask

  task automatic runRow(input int r);
    int n, wSkip, rSkip;
    n = VEC[r][4]; wSkip = VEC[r][2]; rSkip = VEC[r][3];
    wrHalf = VEC[r][0]; rdHalf = VEC[r][1];
    refQ.delete();
    doReset();
    check(rdEmpty === 1'b1 && wrFull === 1'b0 && rdFull === 1'b0, "R1 row reset", int'(rdEmpty), 1);
    fork
      begin : writer
        int i, cyc;
        bit want, seen;
        i = 0; cyc = 0;
        @(posedge wrClk); #1;
        while (i < n) begin
          cyc++;
          want = (wSkip == 0) || (cyc % wSkip != 0);
          wrReq = want; wrData = DW'(8'h10 + i + r * 7); seen = wrFull;
          @(posedge wrClk); #1;
          if (want && !seen) begin
            refQ.push_back(wrData);
            i++;
          end
        end
        wrReq = 1'b0;
      end
      begin : reader
        int k, cyc;
        bit want, seen;
        logic [DW-1:0] v;
        k = 0; cyc = 0;
        @(posedge rdClk); #1;
        while (k < n) begin
          cyc++;
          want = (rSkip == 0) || (cyc % rSkip != 0);
          rdReq = want; seen = rdEmpty; v = rdData;
          @(posedge rdClk); #1;
          if (want && !seen) begin
            popCheck(v, "R2 stream order");   // R9 head word shown ahead
            k++;
          end
        end
        rdReq = 1'b0;
      end
    join
    repeat (6) @(posedge rdClk);
    #1;
    check(rdEmpty === 1'b1, "R8 empty after drain", int'(rdEmpty), 1);
    check(refQ.size() == 0, "R2 no leftover words", refQ.size(), 0);
  endtask

  initial begin : watchdog
    #1_800_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    bit acc, got;
    int accCnt;
    logic [DW-1:0] v;

    // R1: reset values
    #1 rstN = 1'b0;
    #20;
    check(rdEmpty === 1'b1, "R1 empty in reset", int'(rdEmpty), 1);
    check(wrFull === 1'b0, "R1 wrFull in reset", int'(wrFull), 0);
    check(rdFull === 1'b0, "R1 rdFull in reset", int'(rdFull), 0);
    #20 rstN = 1'b1;
    #3;
    check(rdEmpty === 1'b1 && wrFull === 1'b0 && rdFull === 1'b0, "R1 after release", int'(rdEmpty), 1);

    // R4: reads while empty are ignored
    for (int j = 0; j < 3; j++) begin
      rdTry(got, v);
      check(!got, "R4 read while empty", int'(got), 0);
    end
    check(rdEmpty === 1'b1, "R4 still empty", int'(rdEmpty), 1);

    // R8: empty falls at third read edge after the write edge (aligned clocks)
    wrTry(8'h5A, acc);
    check(acc, "R8 write accepted", int'(acc), 1);
    for (int k = 1; k <= 3; k++) begin
      @(posedge rdClk); #1;
      check(rdEmpty === (k < 3), "R8 empty latency", int'(rdEmpty), (k < 3) ? 1 : 0);
    end
    check(rdData === 8'h5A, "R9 head word shown", int'(rdData), 8'h5A);
    rdTry(got, v);
    check(got, "R4 word after ignored reads", int'(got), 1);
    popCheck(v, "R4 pointer unmoved by ignored reads");
    check(rdEmpty === 1'b1, "R8 empty after last word", int'(rdEmpty), 1);

    // R5: fill with the reader idle
    repeat (6) @(posedge wrClk);
    accCnt = 0;
    for (int j = 0; j < DEPTH + 2; j++) begin
      wrTry(DW'(8'hA0 + j), acc);
      if (acc) begin
        accCnt++;
        check(wrFull === (accCnt == LIMIT), "R5 full timing", int'(wrFull), (accCnt == LIMIT) ? 1 : 0);
      end
    end
    check(accCnt == LIMIT, "R5 accepted count", accCnt, LIMIT);
    check(wrFull === 1'b1, "R5 full held", int'(wrFull), 1);

    // R7: read-side full flag
    repeat (6) @(posedge rdClk); #1;
    check(rdFull === 1'b1, "R7 rdFull raised", int'(rdFull), 1);
    check(rdEmpty === 1'b0, "R7 not empty", int'(rdEmpty), 0);
    rdTry(got, v);
    check(got, "R7 read accepted", int'(got), 1);
    popCheck(v, "R3 first word kept");
    check(rdFull === 1'b0, "R7 rdFull cleared by read", int'(rdFull), 0);

    // R6: write full clears at third write edge after the read edge
    for (int k = 1; k <= 3; k++) begin
      @(posedge wrClk); #1;
      check(wrFull === (k < 3), "R6 full release latency", int'(wrFull), (k < 3) ? 1 : 0);
    end

    // R3: the dropped writes never appear
    for (int j = 1; j < LIMIT; j++) begin
      rdTry(got, v);
      check(got, "R3 stored word present", int'(got), 1);
      popCheck(v, "R3 stored word intact");
    end
    rdTry(got, v);
    check(!got, "R3 no dropped word appears", int'(got), 0);
    check(rdEmpty === 1'b1, "R8 empty after drain", int'(rdEmpty), 1);

    // R2: table of clock ratios and gap patterns
    for (int r = 0; r < NROW; r++) begin
      runRow(r);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule